// File: doc/BRIEF.md
# Ethernet SFD Timestamp Capture and Receive Stamp Inserter

This block watches the receive and transmit data streams of an Ethernet MAC, on either a 4-bit (MII) or an 8-bit (GMII) data path, and finds the Start of Frame Delimiter. It latches a free-running time value in the clock cycle after the delimiter is seen. Because of this fixed sampling point, the captured value is offset from the ideal message timestamp point by a known amount that depends on the mode. On receive it is 4 bit times late in MII and 8 bit times late in GMII. On transmit it is early by the same amounts.

On the receive side the block produces the byte stream that a buffer writer stores for each frame. First come the padding-alignment bytes, then the frame bytes that follow the delimiter. When stamping is enabled and the padding length is at least the stamp size, the first padding bytes carry the captured time, most significant byte first, and the other padding bytes are zero. A small internal queue holds the incoming frame bytes while the padding is written. The output is a write strobe with no back-pressure: the consumer must take a byte in every cycle in which `rx_out_valid` is high, because a MAC receive stream cannot be stalled.

On the transmit side the captured time is held in a register with a valid flag until software acknowledges it.

Top module: `sfd_tstamp`

## Requirements
- R1: While reset is low, and in the cycle after it, `rx_out_valid`, `rx_out_last` and `tx_stamp_valid` are 0.
- R2: With `mode_gmii`=1, a delimiter is recognised when a beat with data-valid high carrying 0xD5 follows one or more beats of 0x55. The frame bytes after the delimiter are passed through unchanged.
- R3: With `mode_gmii`=0, only bits [3:0] are used. The preamble nibble is 0x5 and the delimiter nibble is 0xD after a 0x5. Frame bytes are built low nibble first, and an odd trailing nibble is dropped.
- R4: The time value present in the cycle after the delimiter beat is the one captured, on both receive and transmit.
- R5: If `ts_en`=1 and `pad_len` ≥ 8 (both sampled in the cycle after the delimiter), the receive stream starts with the 8 stamp bytes, most significant first. It continues with `pad_len`-8 zero bytes and then the frame bytes.
- R6: If `ts_en`=0 or `pad_len` < 8, the receive stream is `pad_len` zero bytes followed by the frame bytes. With `pad_len`=0 it is the frame bytes alone.
- R7: `rx_out_last` is high with the final frame byte only, and the byte count equals `pad_len` plus the number of frame bytes.
- R8: If data-valid drops before the delimiter, or a beat that is neither preamble nor delimiter comes first, the frame produces no capture and no output bytes.
- R9: Only one capture is made per frame. A 0x55 0xD5 pattern inside the frame is passed through as data.
- R10: While `tx_stamp_valid` is high and no acknowledge arrives, `tx_stamp` holds its value, and a new transmit capture is discarded.
- R11: A pulse on `tx_stamp_ack` while `tx_stamp_valid` is high clears the flag in the next cycle, and the next transmit delimiter then loads a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_gmii | input | 1 | 1: byte-wide data path, 0: nibble-wide |
| rx_data | input | 8 | Receive data beat |
| rx_dv | input | 1 | Receive data valid |
| tx_data | input | 8 | Transmit data beat |
| tx_en | input | 1 | Transmit enable |
| time_now | input | TIME_W | Free-running time value |
| pad_len | input | PAD_W | Padding-alignment length in bytes |
| ts_en | input | 1 | Receive stamp enable |
| rx_out_valid | output | 1 | Receive buffer byte strobe |
| rx_out_data | output | 8 | Receive buffer byte |
| rx_out_last | output | 1 | Final byte of the frame |
| tx_stamp | output | TIME_W | Captured transmit time |
| tx_stamp_valid | output | 1 | Transmit capture held |
| tx_stamp_ack | input | 1 | Clears the transmit capture |

## Verification
The bench builds the block with its defaults: a 64-bit time value and a 4-bit padding length. This allows padding of 0 to 15 bytes, so it covers no padding, padding below the stamp size, exactly 8 bytes, and padding with zero bytes after the stamp, all on a 32-entry frame queue. Time is given a distinct value in every byte, which exposes errors in byte order and in the capture cycle. Frames run in both data-path widths, including aborted preambles, an odd trailing nibble and a delimiter pattern inside the payload.

// File: rtl/sfd_tstamp_pkg.sv
package sfd_tstamp_pkg;
  typedef enum logic [1:0] {
    DET_HUNT  = 2'd0,
    DET_PRE   = 2'd1,
    DET_FRAME = 2'd2,
    DET_SKIP  = 2'd3
  } det_state_e;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;
  localparam logic [7:0] PRE_NIB  = 8'h05;
  localparam logic [7:0] SFD_NIB  = 8'h0D;
endpackage

// File: rtl/sfd_tstamp_detect.sv
module sfd_tstamp_detect
  import sfd_tstamp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gmii,
  input  logic [7:0] data,
  input  logic       dv,
  output logic       sfd_pulse
);
  det_state_e state;
  logic [7:0] beat, pre_code, sfd_code;

  always_comb begin
    beat     = gmii ? data : {4'h0, data[3:0]};
    pre_code = gmii ? PRE_BYTE : PRE_NIB;
    sfd_code = gmii ? SFD_BYTE : SFD_NIB;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= DET_HUNT;
      sfd_pulse <= 1'b0;
    end else begin
      sfd_pulse <= 1'b0;
      if (!dv) begin
        state <= DET_HUNT;
      end else begin
        case (state)
          DET_HUNT: state <= (beat == pre_code) ? DET_PRE : DET_SKIP;
          DET_PRE: begin
            if (beat == sfd_code) begin
              state     <= DET_FRAME;
              sfd_pulse <= 1'b1;
            end else if (beat != pre_code) begin
              state <= DET_SKIP;
            end
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/sfd_tstamp_assemble.sv
module sfd_tstamp_assemble (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gmii,
  input  logic [7:0] data,
  input  logic       dv,
  input  logic       sfd,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  logic       active, half, pend_vld;
  logic [3:0] lo_nib;
  logic [7:0] pend;
  logic       take, asm_vld;
  logic [7:0] asm_byte;

  always_comb begin
    take     = dv && (sfd || active);
    asm_vld  = take && (gmii || half);
    asm_byte = gmii ? data : {data[3:0], lo_nib};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      half      <= 1'b0;
      pend_vld  <= 1'b0;
      lo_nib    <= '0;
      pend      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (!dv) begin
        active <= 1'b0;
        half   <= 1'b0;
        if (pend_vld) begin
          out_valid <= 1'b1;
          out_data  <= pend;
          out_last  <= 1'b1;
          pend_vld  <= 1'b0;
        end
      end else begin
        if (take) active <= 1'b1;
        if (take && !gmii) begin
          if (!half) begin
            lo_nib <= data[3:0];
            half   <= 1'b1;
          end else begin
            half <= 1'b0;
          end
        end
        if (asm_vld) begin
          if (pend_vld) begin
            out_valid <= 1'b1;
            out_data  <= pend;
          end
          pend     <= asm_byte;
          pend_vld <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sfd_tstamp_fifo.sv
module sfd_tstamp_fifo #(
  parameter int W  = 9,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic [AW:0]   count
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;

  always_comb begin
    count = wr_ptr - rd_ptr;
    empty = (count == '0);
    dout  = mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/sfd_tstamp_insert.sv
module sfd_tstamp_insert #(
  parameter int TIME_W = 64,
  parameter int PAD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfd,
  input  logic [TIME_W-1:0] time_now,
  input  logic [PAD_W-1:0]  pad_len,
  input  logic              ts_en,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last
);
  localparam int STAMP_BYTES = TIME_W / 8;
  localparam int AW = PAD_W + 1;
  localparam logic [PAD_W-1:0] STAMP_CNT = PAD_W'(STAMP_BYTES);

  logic [TIME_W-1:0] shreg;
  logic [PAD_W-1:0]  pad_tot, pad_idx;
  logic              pad_busy, stamp_on;
  logic [AW:0]       old_left;
  logic [8:0]        q_dout;
  logic              q_empty;
  logic [AW:0]       q_count;
  logic              drain_old, do_pad, do_pop, stamp_byte;

  sfd_tstamp_fifo #(.W(9), .AW(AW)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid),
    .din   ({in_last, in_data}),
    .pop   (do_pop),
    .dout  (q_dout),
    .empty (q_empty),
    .count (q_count)
  );

  always_comb begin
    drain_old  = (old_left != '0);
    do_pad     = pad_busy && !drain_old;
    do_pop     = !q_empty && !do_pad;
    stamp_byte = stamp_on && (pad_idx < STAMP_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      pad_tot   <= '0;
      pad_idx   <= '0;
      pad_busy  <= 1'b0;
      stamp_on  <= 1'b0;
      old_left  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (do_pad) begin
        out_valid <= 1'b1;
        out_data  <= stamp_byte ? shreg[TIME_W-1 -: 8] : 8'h00;
        if (stamp_byte) shreg <= shreg << 8;
        pad_idx <= pad_idx + 1'b1;
        if (pad_idx == pad_tot - 1'b1) pad_busy <= 1'b0;
      end else if (do_pop) begin
        out_valid <= 1'b1;
        out_data  <= q_dout[7:0];
        out_last  <= q_dout[8];
        if (drain_old) old_left <= old_left - 1'b1;
      end
      if (sfd) begin
        shreg    <= time_now;
        pad_tot  <= pad_len;
        pad_idx  <= '0;
        pad_busy <= (pad_len != '0);
        stamp_on <= ts_en && (pad_len >= STAMP_CNT);
        old_left <= q_count - (AW+1)'(do_pop);
      end
    end
  end
endmodule

// File: rtl/sfd_tstamp_txcap.sv
module sfd_tstamp_txcap #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfd,
  input  logic [TIME_W-1:0] time_now,
  input  logic              ack,
  output logic [TIME_W-1:0] stamp,
  output logic              stamp_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp       <= '0;
      stamp_valid <= 1'b0;
    end else if (sfd && !stamp_valid) begin
      stamp       <= time_now;
      stamp_valid <= 1'b1;
    end else if (ack) begin
      stamp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sfd_tstamp.sv
module sfd_tstamp #(
  parameter int TIME_W = 64,
  parameter int PAD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_gmii,
  input  logic [7:0]        rx_data,
  input  logic              rx_dv,
  input  logic [7:0]        tx_data,
  input  logic              tx_en,
  input  logic [TIME_W-1:0] time_now,
  input  logic [PAD_W-1:0]  pad_len,
  input  logic              ts_en,
  output logic              rx_out_valid,
  output logic [7:0]        rx_out_data,
  output logic              rx_out_last,
  output logic [TIME_W-1:0] tx_stamp,
  output logic              tx_stamp_valid,
  input  logic              tx_stamp_ack
);
  localparam int NPATH = 2;

  logic [7:0] path_data [NPATH];
  logic       path_dv   [NPATH];
  logic       path_sfd  [NPATH];
  logic       fr_valid, fr_last;
  logic [7:0] fr_data;

  always_comb begin
    path_data[0] = rx_data;
    path_dv[0]   = rx_dv;
    path_data[1] = tx_data;
    path_dv[1]   = tx_en;
  end

  for (genvar p = 0; p < NPATH; p++) begin : g_det
    sfd_tstamp_detect u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .gmii      (mode_gmii),
      .data      (path_data[p]),
      .dv        (path_dv[p]),
      .sfd_pulse (path_sfd[p])
    );
  end

  sfd_tstamp_assemble u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .gmii      (mode_gmii),
    .data      (rx_data),
    .dv        (rx_dv),
    .sfd       (path_sfd[0]),
    .out_valid (fr_valid),
    .out_data  (fr_data),
    .out_last  (fr_last)
  );

  sfd_tstamp_insert #(.TIME_W(TIME_W), .PAD_W(PAD_W)) u_ins (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfd       (path_sfd[0]),
    .time_now  (time_now),
    .pad_len   (pad_len),
    .ts_en     (ts_en),
    .in_valid  (fr_valid),
    .in_data   (fr_data),
    .in_last   (fr_last),
    .out_valid (rx_out_valid),
    .out_data  (rx_out_data),
    .out_last  (rx_out_last)
  );

  sfd_tstamp_txcap #(.TIME_W(TIME_W)) u_txcap (
    .clk         (clk),
    .rst_n       (rst_n),
    .sfd         (path_sfd[1]),
    .time_now    (time_now),
    .ack         (tx_stamp_ack),
    .stamp       (tx_stamp),
    .stamp_valid (tx_stamp_valid)
  );
endmodule

// File: rtl/sfd_tstamp_chk.sv
module sfd_tstamp_chk #(
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              rx_out_valid,
  input logic              rx_out_last,
  input logic [TIME_W-1:0] tx_stamp,
  input logic              tx_stamp_valid,
  input logic              tx_stamp_ack
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!rx_out_valid && !rx_out_last && !tx_stamp_valid));

  // R7
  a_r7_last_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_last |-> rx_out_valid);

  // R10
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stamp_valid && !tx_stamp_ack) |=> (tx_stamp_valid && $stable(tx_stamp)));

  // R11
  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stamp_valid && tx_stamp_ack) |=> !tx_stamp_valid);

  // R4
  a_r4_tx_capture_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_stamp_valid) |-> $past(tx_en, 2));
endmodule

bind sfd_tstamp sfd_tstamp_chk #(.TIME_W(TIME_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_en          (tx_en),
  .rx_out_valid   (rx_out_valid),
  .rx_out_last    (rx_out_last),
  .tx_stamp       (tx_stamp),
  .tx_stamp_valid (tx_stamp_valid),
  .tx_stamp_ack   (tx_stamp_ack)
);

// File: tb/sfd_tstamp_bench.sv
`timescale 1ns/1ps
module sfd_tstamp_bench;
  localparam int TIME_W = 64;
  localparam int PAD_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_gmii = 1'b1;
  logic [7:0]        rx_data = '0, tx_data = '0;
  logic              rx_dv = 1'b0, tx_en = 1'b0;
  logic [TIME_W-1:0] tnow = 64'h0123_4567_89AB_C000;
  logic [PAD_W-1:0]  pad_len = '0;
  logic              ts_en = 1'b0;
  logic              rx_out_valid, rx_out_last, tx_stamp_valid;
  logic [7:0]        rx_out_data;
  logic [TIME_W-1:0] tx_stamp;
  logic              tx_stamp_ack = 1'b0;

  int checks = 0, failures = 0;
  logic [7:0] pay [0:63];
  int         pay_n;
  logic [7:0] got_d [0:127];
  logic       got_l [0:127];
  int         got_n = 0;
  logic [TIME_W-1:0] cap_time;

  always #2.5 clk = ~clk;
  always @(posedge clk) tnow <= tnow + 1;

  sfd_tstamp #(.TIME_W(TIME_W), .PAD_W(PAD_W)) u_sfd_tstamp (
    .clk(clk), .rst_n(rst_n), .mode_gmii(mode_gmii),
    .rx_data(rx_data), .rx_dv(rx_dv), .tx_data(tx_data), .tx_en(tx_en),
    .time_now(tnow), .pad_len(pad_len), .ts_en(ts_en),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_last(rx_out_last),
    .tx_stamp(tx_stamp), .tx_stamp_valid(tx_stamp_valid), .tx_stamp_ack(tx_stamp_ack)
  );

  always @(negedge clk) begin
    if (rst_n && rx_out_valid && got_n < 128) begin
      got_d[got_n] = rx_out_data;
      got_l[got_n] = rx_out_last;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat(input bit tx, input logic [7:0] v, input bit dv);
    @(negedge clk);
    if (tx) begin tx_data = v; tx_en = dv; end
    else begin rx_data = v; rx_dv = dv; end
  endtask

  task automatic put_byte(input bit tx, input logic [7:0] v, inout bit after_sfd);
    if (mode_gmii) begin
      beat(tx, v, 1'b1);
      if (after_sfd) begin cap_time = tnow; after_sfd = 1'b0; end
    end else begin
      beat(tx, {4'h0, v[3:0]}, 1'b1);
      if (after_sfd) begin cap_time = tnow; after_sfd = 1'b0; end
      beat(tx, {4'h0, v[7:4]}, 1'b1);
    end
  endtask

  // npre preamble bytes, then optional SFD, then payload, optional odd nibble
  task automatic send(input bit tx, input int npre, input bit with_sfd, input bit odd);
    bit flag = 1'b0;
    for (int i = 0; i < npre; i++) put_byte(tx, 8'h55, flag);
    if (with_sfd) begin
      put_byte(tx, 8'hD5, flag);
      flag = 1'b1;
      for (int i = 0; i < pay_n; i++) put_byte(tx, pay[i], flag);
      if (odd) beat(tx, 8'h0A, 1'b1);
    end
    beat(tx, 8'h00, 1'b0);
    repeat (40) @(negedge clk);
  endtask

  task automatic fill(input logic [7:0] seed, input int n);
    pay_n = n;
    for (int i = 0; i < n; i++) pay[i] = seed + 8'(i * 37);
  endtask

  task automatic check_rx(input int pad, input bit ts, input string req_pad, input string req_pay);
    logic [7:0] e;
    chk(got_n == pad + pay_n, "R7", 64'(got_n), 64'(pad + pay_n));
    if (got_n == pad + pay_n) begin
      for (int i = 0; i < got_n; i++) begin
        if (i < pad) e = (ts && pad >= 8 && i < 8) ? cap_time[63 - 8*i -: 8] : 8'h00;
        else e = pay[i - pad];
        chk(got_d[i] == e, (i < pad) ? req_pad : req_pay, 64'(got_d[i]), 64'(e));
        chk(got_l[i] == (i == got_n - 1), "R7", 64'(got_l[i]), 64'(i == got_n - 1));
      end
    end
  endtask

  task automatic rx_case(input bit gmii, input int pad, input bit ts, input bit odd,
                         input string req_pad, input string req_pay);
    @(negedge clk);
    mode_gmii = gmii; pad_len = PAD_W'(pad); ts_en = ts; got_n = 0;
    send(1'b0, 7, 1'b1, odd);
    check_rx(pad, ts, req_pad, req_pay);
  endtask

  task automatic t_reset;
    chk(!rx_out_valid && !rx_out_last && !tx_stamp_valid, "R1",
        64'({rx_out_valid, rx_out_last, tx_stamp_valid}), 64'h0);
  endtask

  task automatic t_abort;
    @(negedge clk);
    mode_gmii = 1'b1; pad_len = 4'd8; ts_en = 1'b1; got_n = 0;
    fill(8'h10, 4);
    send(1'b0, 3, 1'b0, 1'b0);                // dv drops during preamble
    beat(1'b0, 8'h33, 1'b1);                  // bad first octet
    send(1'b0, 3, 1'b1, 1'b0);                // SFD after junk must be ignored
    chk(got_n == 0, "R8", 64'(got_n), 64'h0);
    send(1'b1, 2, 1'b0, 1'b0);
    chk(!tx_stamp_valid, "R8", 64'(tx_stamp_valid), 64'h0);
  endtask

  task automatic t_payload_sfd;
    fill(8'h20, 6);
    pay[1] = 8'h55; pay[2] = 8'hD5; pay[3] = 8'h55; pay[4] = 8'hD5;
    rx_case(1'b1, 8, 1'b1, 1'b0, "R9", "R9");
  endtask

  task automatic t_tx;
    logic [TIME_W-1:0] first;
    @(negedge clk);
    mode_gmii = 1'b1; fill(8'h40, 5);
    send(1'b1, 7, 1'b1, 1'b0);
    chk(tx_stamp_valid, "R4", 64'(tx_stamp_valid), 64'h1);
    chk(tx_stamp == cap_time, "R4", tx_stamp, cap_time);
    first = cap_time;
    send(1'b1, 7, 1'b1, 1'b0);
    chk(tx_stamp == first, "R10", tx_stamp, first);
    chk(tx_stamp_valid, "R10", 64'(tx_stamp_valid), 64'h1);
    @(negedge clk); tx_stamp_ack = 1'b1;
    @(negedge clk); tx_stamp_ack = 1'b0;
    chk(!tx_stamp_valid, "R11", 64'(tx_stamp_valid), 64'h0);
    mode_gmii = 1'b0;
    send(1'b1, 7, 1'b1, 1'b0);
    chk(tx_stamp_valid && tx_stamp == cap_time, "R11", tx_stamp, cap_time);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    fill(8'h01, 6);  rx_case(1'b1, 8,  1'b1, 1'b0, "R5", "R2");
    fill(8'h07, 5);  rx_case(1'b1, 12, 1'b1, 1'b0, "R5", "R2");
    fill(8'h0B, 4);  rx_case(1'b1, 5,  1'b1, 1'b0, "R6", "R2");
    fill(8'h2C, 7);  rx_case(1'b1, 10, 1'b0, 1'b0, "R6", "R2");
    fill(8'h31, 3);  rx_case(1'b1, 0,  1'b1, 1'b0, "R6", "R2");
    fill(8'h5A, 6);  rx_case(1'b0, 8,  1'b1, 1'b0, "R4", "R3");
    fill(8'h6E, 5);  rx_case(1'b0, 15, 1'b1, 1'b1, "R5", "R3");
    t_abort;
    t_payload_sfd;
    t_tx;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule